// File: doc/BRIEF.md
# Supply-aware reset and clock sequencer

This controller sits between an already synchronised supply-good level and a microcontroller. It drives a reset pair (active-high and active-low) and a gated output clock derived from a free-running reference clock. A restartable timebase divides the reference clock into millisecond ticks, and every interval in the sequence is counted in those ticks.

When the supply becomes good, reset is held for a long stabilisation window. The output clock stays low for most of that window, so the load can charge its supply rails without the processor drawing current. The clock starts at the normal rate (reference divided by two) for the last part of the window and keeps running after reset is released. When the supply drops, reset asserts in the same reference cycle. The output clock then falls to a reduced rate, a power-of-two division of the normal clock, for a fixed window, and is then parked low until the next power-up. A return of the supply at any point restarts the full sequence from its beginning.

Top module: `sup_seq_ctrl`

## Requirements
- R1: After supply_ok_i is first sampled high, rst_o stays high for exactly RST_MS*TICK_DIV reference cycles and then falls.
- R2: During that window clk_o stays low until CLK_LEAD_MS ms before release. Its first rising edge comes 3 reference cycles after that point. From then on it toggles every reference cycle (period 2), including after release.
- R3: A low supply_ok_i forces rst_o high and rst_no low combinationally, in the same reference cycle, without waiting for a tick.
- R4: After a supply drop from a clocked state, clk_o settles to a period of 2^(SLOW_LOG2+1) reference cycles.
- R5: The reduced clock has no rising edge later than SLOW_MS*TICK_DIV cycles after the drop, and has one within its last slow period. clk_o is low from SLOW_MS*TICK_DIV + 2^SLOW_LOG2 + 2 cycles on, and reset stays high.
- R6: rst_no is always the exact complement of rst_o.
- R7: If the supply returns during the reduced-clock or stopped phase, reset stays high and the full R1/R2 sequence restarts from zero.
- R8: Every high phase of clk_o lasts either 1 or 2^SLOW_LOG2 reference cycles. A rate change or a stop takes effect only while clk_o is low.
- R9: While rst_ni is low, and afterwards until the supply is good, rst_o is high, rst_no is low and clk_o is low.
- R10: A supply drop during the clock-less part of power-up returns the block to idle. The next rise of the supply runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| supply_ok_i | input | 1 | Synchronised supply-good level |
| rst_o | output | 1 | Reset to the load, active high |
| rst_no | output | 1 | Reset to the load, active low |
| clk_o | output | 1 | Gated output clock |

## Verification
The reset edges are due a fixed number of cycles after the supply edge: the assertion is combinational and so visible 1 ns after the input changes, and the release comes exactly RST_MS*TICK_DIV samples later. The first output clock edge comes three cycles after the lead point, because of the state register, the mode register and the toggle flop. The bench drives every input at a falling edge and samples every output at falling edges. It counts those samples from the stimulus and compares each counted index with values it computes from the tick parameters. For the reduced clock, a mode change can land at either phase of the normal clock. The bench therefore checks only the spacing between slow rising edges after the first few cycles, a window for the last edge, and a fixed cycle after which the output must stay low.

// File: rtl/sup_seq_pkg.sv
package sup_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWRUP_WAIT,
    ST_PWRUP_CLK,
    ST_RUN,
    ST_BROWNOUT_SLOW,
    ST_STOPPED
  } seq_state_e;

  typedef enum logic [1:0] {
    CM_OFF,
    CM_NORM,
    CM_SLOW
  } clk_mode_e;
endpackage

// File: rtl/sup_seq_tick.sv
module sup_seq_tick #(
  parameter int unsigned TICK_DIV = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/sup_seq_fsm.sv
module sup_seq_fsm
  import sup_seq_pkg::*;
#(
  parameter int unsigned RST_MS      = 12,
  parameter int unsigned CLK_LEAD_MS = 1,
  parameter int unsigned SLOW_MS     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       tick_i,
  output logic       tick_clr_o,
  output seq_state_e state_o,
  output clk_mode_e  clk_req_o,
  output logic       rst_act_o
);
  localparam int unsigned WAIT_MS = RST_MS - CLK_LEAD_MS;
  localparam int unsigned MAX_MS  = (RST_MS > SLOW_MS) ? RST_MS : SLOW_MS;
  localparam int unsigned MW      = $clog2(MAX_MS + 1);
  localparam logic [MW-1:0] WAIT_LAST = MW'(WAIT_MS - 1);
  localparam logic [MW-1:0] RST_LAST  = MW'(RST_MS - 1);
  localparam logic [MW-1:0] SLOW_LAST = MW'(SLOW_MS - 1);

  seq_state_e    state_q, state_d;
  logic [MW-1:0] ms_q;
  logic          restart;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:        if (supply_ok_i) state_d = ST_PWRUP_WAIT;
      ST_PWRUP_WAIT: begin
        if (!supply_ok_i) state_d = ST_OFF;
        else if (tick_i && ms_q == WAIT_LAST) state_d = ST_PWRUP_CLK;
      end
      ST_PWRUP_CLK: begin
        if (!supply_ok_i) state_d = ST_BROWNOUT_SLOW;
        else if (tick_i && ms_q == RST_LAST) state_d = ST_RUN;
      end
      ST_RUN:        if (!supply_ok_i) state_d = ST_BROWNOUT_SLOW;
      ST_BROWNOUT_SLOW: begin
        if (supply_ok_i) state_d = ST_PWRUP_WAIT;
        else if (tick_i && ms_q == SLOW_LAST) state_d = ST_STOPPED;
      end
      ST_STOPPED:    if (supply_ok_i) state_d = ST_PWRUP_WAIT;
      default:       state_d = ST_OFF;
    endcase
  end

  // timed phases start from a clean tick boundary
  assign restart = (state_d != state_q) &&
                   (state_d == ST_PWRUP_WAIT || state_d == ST_BROWNOUT_SLOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      ms_q    <= '0;
    end else begin
      state_q <= state_d;
      if (restart) ms_q <= '0;
      else if (tick_i) ms_q <= ms_q + 1'b1;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PWRUP_CLK, ST_RUN: clk_req_o = CM_NORM;
      ST_BROWNOUT_SLOW:     clk_req_o = CM_SLOW;
      default:              clk_req_o = CM_OFF;
    endcase
  end

  assign tick_clr_o = restart;
  assign state_o    = state_q;
  assign rst_act_o  = !supply_ok_i || (state_q != ST_RUN);
endmodule

// File: rtl/sup_seq_clkgen.sv
module sup_seq_clkgen
  import sup_seq_pkg::*;
#(
  parameter int unsigned SLOW_LOG2 = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  clk_mode_e req_i,
  output logic      clk_o
);
  localparam int unsigned CW = (SLOW_LOG2 > 0) ? SLOW_LOG2 : 1;

  clk_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic          clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CM_OFF;
      cnt_q  <= '0;
      clk_q  <= 1'b0;
    end else if (!clk_q && mode_q != req_i) begin
      // adopt a new mode only in the low phase
      mode_q <= req_i;
      cnt_q  <= '0;
    end else begin
      unique case (mode_q)
        CM_NORM: clk_q <= ~clk_q;
        CM_SLOW: begin
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q) clk_q <= ~clk_q;
        end
        default: clk_q <= 1'b0;
      endcase
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/sup_seq_ctrl.sv
module sup_seq_ctrl
  import sup_seq_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 8000,
  parameter int unsigned RST_MS      = 12,
  parameter int unsigned CLK_LEAD_MS = 1,
  parameter int unsigned SLOW_MS     = 2,
  parameter int unsigned SLOW_LOG2   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  output logic rst_o,
  output logic rst_no,
  output logic clk_o
);
  logic       tick, tick_clr, rst_act;
  seq_state_e state_q;
  clk_mode_e  clk_req;

  sup_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .tick_o(tick)
  );

  sup_seq_fsm #(
    .RST_MS     (RST_MS),
    .CLK_LEAD_MS(CLK_LEAD_MS),
    .SLOW_MS    (SLOW_MS)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .tick_i     (tick),
    .tick_clr_o (tick_clr),
    .state_o    (state_q),
    .clk_req_o  (clk_req),
    .rst_act_o  (rst_act)
  );

  sup_seq_clkgen #(.SLOW_LOG2(SLOW_LOG2)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (clk_req),
    .clk_o (clk_o)
  );

  assign rst_o  = rst_act;
  assign rst_no = ~rst_act;
endmodule

// File: rtl/sup_seq_chk.sv
module sup_seq_chk
  import sup_seq_pkg::*;
#(
  parameter int unsigned MIN_RST = 96000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       supply_ok_i,
  input logic       rst_o,
  input logic       rst_no,
  input logic       clk_o,
  input seq_state_e state_i
);
  logic [31:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_cnt <= '0;
    else if (!supply_ok_i) hold_cnt <= '0;
    else if (rst_o && hold_cnt != '1) hold_cnt <= hold_cnt + 1'b1;
  end

  // R6
  rst_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == !rst_no);

  // R3
  drop_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> rst_o);

  // R1
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> hold_cnt >= MIN_RST);

  // R2 R5
  clk_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> ($past(state_i) == ST_PWRUP_CLK || $past(state_i) == ST_RUN ||
                      $past(state_i) == ST_BROWNOUT_SLOW));

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_STOPPED || state_i == ST_BROWNOUT_SLOW) && supply_ok_i)
      |=> (state_i == ST_PWRUP_WAIT && rst_o));

  // R10
  early_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PWRUP_WAIT && !supply_ok_i) |=> state_i == ST_OFF);

  // R9
  por_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rst_o && !clk_o));
endmodule

bind sup_seq_ctrl sup_seq_chk #(.MIN_RST(RST_MS * TICK_DIV)) u_sup_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .rst_o      (rst_o),
  .rst_no     (rst_no),
  .clk_o      (clk_o),
  .state_i    (state_q)
);

// File: tb/sup_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sup_seq_ctrl_bench;
  localparam int TICK_DIV  = 32;
  localparam int RST_MS    = 12;
  localparam int LEAD_MS   = 1;
  localparam int SLOW_MS   = 2;
  localparam int SLOW_LOG2 = 2;
  localparam int HOLD      = RST_MS * TICK_DIV;
  localparam int CLK_FIRST = (RST_MS - LEAD_MS) * TICK_DIV + 3;
  localparam int HALF_SLOW = 1 << SLOW_LOG2;
  localparam int SLOW_PER  = 2 * HALF_SLOW;
  localparam int SLOW_WIN  = SLOW_MS * TICK_DIV;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0;
  logic rst_o, rst_no, clk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;
  bit prev_mon = 1'b0;
  int hi_run = 0;

  always #2.5 clk = ~clk;

  sup_seq_ctrl #(
    .TICK_DIV   (TICK_DIV),
    .RST_MS     (RST_MS),
    .CLK_LEAD_MS(LEAD_MS),
    .SLOW_MS    (SLOW_MS),
    .SLOW_LOG2  (SLOW_LOG2)
  ) u_sup_seq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok),
    .rst_o      (rst_o),
    .rst_no     (rst_no),
    .clk_o      (clk_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R6 and R8 monitor
  always @(negedge clk) begin
    if (mon_en) begin
      check(rst_o == !rst_no, "R6 complement", int'(rst_no), int'(!rst_o));
      if (clk_o) hi_run++;
      else if (prev_mon) begin
        check(hi_run == 1 || hi_run == HALF_SLOW, "R8 high phase", hi_run, HALF_SLOW);
        hi_run = 0;
      end
      prev_mon = clk_o;
    end
  end

  task automatic do_powerup(input string req);
    int hi = 0;
    int r1 = 0;
    int r2 = 0;
    bit prev = clk_o;
    supply_ok = 1'b1;
    for (int i = 1; i <= HOLD + 40; i++) begin
      @(negedge clk);
      if (rst_o) hi++;
      if (i > 8 && clk_o && !prev) begin
        if (r1 == 0) r1 = i;
        else if (r2 == 0) r2 = i;
      end
      prev = clk_o;
      if (!rst_o) break;
    end
    check(hi == HOLD, {req, " hold"}, hi, HOLD);
    check(r1 == CLK_FIRST, {req, " R2 clock start"}, r1, CLK_FIRST);
    check(r2 - r1 == 2, {req, " R2 normal period"}, r2 - r1, 2);
  endtask

  task automatic do_brownout();
    int last = 0;
    int prev_rise = 0;
    int late = 0;
    int rst_lo = 0;
    bit prev;
    supply_ok = 1'b0;
    #1;
    check(rst_o == 1'b1 && rst_no == 1'b0, "R3 immediate reset", int'(rst_o), 1);
    prev = clk_o;
    for (int j = 1; j <= SLOW_WIN + HALF_SLOW + 2 + 3 * SLOW_WIN; j++) begin
      @(negedge clk);
      if (!rst_o) rst_lo++;
      if (clk_o && !prev) begin
        if (prev_rise >= 4) check(j - prev_rise == SLOW_PER, "R4 slow period", j - prev_rise, SLOW_PER);
        prev_rise = j;
        last = j;
      end
      if (j >= SLOW_WIN + HALF_SLOW + 2 && clk_o) late++;
      prev = clk_o;
    end
    check(last <= SLOW_WIN + 1 && last > SLOW_WIN + 1 - SLOW_PER, "R5 last slow edge", last, SLOW_WIN + 1);
    check(late == 0, "R5 clock parked low", late, 0);
    check(rst_lo == 0, "R5 reset held", rst_lo, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9 during reset
    check(rst_o == 1'b1, "R9 rst_o in reset", int'(rst_o), 1);
    check(rst_no == 1'b0, "R9 rst_no in reset", int'(rst_no), 0);
    check(clk_o == 1'b0, "R9 clk_o in reset", int'(clk_o), 0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    repeat (10) @(negedge clk);
    check(rst_o == 1'b1 && clk_o == 1'b0, "R9 idle without supply", int'(clk_o), 0);

    do_powerup("R1");
    begin
      int rises = 0;
      bit prev = clk_o;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (clk_o && !prev) rises++;
        prev = clk_o;
      end
      check(rises == 20, "R2 clock in run", rises, 20);
    end

    do_brownout();
    do_powerup("R7 from stopped");

    // R7: return during the reduced-clock phase
    supply_ok = 1'b0;
    #1;
    check(rst_o == 1'b1, "R3 drop from run", int'(rst_o), 1);
    begin
      int lo = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (!rst_o) lo++;
      end
      check(lo == 0, "R7 reset during slow phase", lo, 0);
    end
    do_powerup("R7 mid slow");

    // R10: drop before the clock starts
    do_brownout();
    supply_ok = 1'b1;
    repeat (100) @(negedge clk);
    check(clk_o == 1'b0 && rst_o == 1'b1, "R10 clock off early in power-up", int'(clk_o), 0);
    supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    check(rst_o == 1'b1 && clk_o == 1'b0, "R10 idle after early drop", int'(rst_o), 1);
    do_powerup("R10");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    summary();
    $finish;
  end
endmodule